// File: doc/BRIEF.md
# Quadrature Encoder Position Tracker

This block turns the two phase signals of an incremental rotary or linear encoder into a signed position count. The two phases, A and B, and the once-per-revolution index mark are asynchronous pins. Each pin passes through a synchroniser and a three-sample majority filter. The cleaned phases are then decoded at four counts per cycle, so every legal edge of either phase moves the count by one in the direction of travel.

Around the counter sit three measurement functions. On the rising edge of the filtered index mark, the count is copied into a snapshot register, which holds its value until software reads it. The block also measures speed: at the end of every timed window it stores how far the position moved during that window. A match detector emits a single-cycle pulse when the position arrives at a programmed target.

Software reaches all of this through a plain register port: a 3-bit address, a read strobe, a write strobe, write data and registered read data. That port has no handshake and never stalls; each access completes in one cycle.

Top module: `qenc_tracker`

## Requirements
- R1: Each of A, B and index is synchronised and then majority-filtered over three samples. A level that lasts only one clock on a pin has no effect on the position. A real edge reaches the position register six clocks after the pin changes.
- R2: The phases are read as {A,B}. The forward sequence 00→01→11→10→00 adds one per transition. The reverse sequence subtracts one. Register POS (address 0) reads the position.
- R3: If both phases change in the same filtered sample, the position does not change and the sticky error bit (STATUS, address 2, bit 1) is set. Writing STATUS with bit 1 high clears the error bit, unless a new jump occurs in the same cycle.
- R4: Writing POS loads the position, and the load takes priority over counting in that cycle. The position is 32-bit two's complement and wraps from 0x7FFFFFFF to 0x80000000.
- R5: On a rising edge of the filtered index while no snapshot is pending, the position register's value in that cycle is copied to SNAP (address 1). The pending bit (STATUS bit 0) is then set.
- R6: While the pending bit is set, later index edges leave SNAP unchanged. A read of SNAP clears the pending bit.
- R7: The window length register WIN (address 4, 24 bits, reset value 100) sets the window in clocks. Writing WIN restarts the window. At each window end, VEL (address 3) takes the signed change in position over that window. A length of 0 stops the measurement. Writes to VEL, and to addresses 6 and 7, are ignored.
- R8: The output `cmp_pulse` is high for exactly one clock, in the cycle after the position becomes equal to TGT (address 5). This happens after the position was unequal to TGT in the previous cycle, whichever direction the position approached from. TGT resets to 0 and does not pulse at reset.
- R9: `reg_rdata` is registered. It shows the addressed register one clock after `reg_rd` and is zero in every other cycle. Writes take effect at the clock edge where `reg_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| enc_idx | input | 1 | Index mark, asynchronous |
| reg_addr | input | 3 | Register address |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one clock after the strobe |
| cmp_pulse | output | 1 | One-clock target match pulse |

## Verification
The hardest case to reach from the pins is a simultaneous change of both phases. The filters run in lockstep, so the bench drives A and B to the opposite Gray state on the same clock; the jump then reaches the decoder intact. The bench also reaches the snapshot-hold case: it fires a second index edge while a snapshot is still pending, with the encoder moved in between, and checks that the first value survives until it is read. A behavioural model, written as a per-clock pipeline of sample vectors, predicts `cmp_pulse` and `reg_rdata` on every clock.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] RA_POS  = 3'd0;
  localparam logic [ADDR_W-1:0] RA_SNAP = 3'd1;
  localparam logic [ADDR_W-1:0] RA_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] RA_VEL  = 3'd3;
  localparam logic [ADDR_W-1:0] RA_WIN  = 3'd4;
  localparam logic [ADDR_W-1:0] RA_TGT  = 3'd5;
  localparam int ST_PEND = 0;
  localparam int ST_ERR  = 1;
  localparam int NUM_PINS = 3;
endpackage

// File: rtl/qenc_pin_filter.sv
module qenc_pin_filter #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic pin_out
);
  logic [SYNC_DEPTH-1:0] sync_q;
  logic [2:0]            hist_q;
  logic                  vote;

  assign vote = (hist_q[0] & hist_q[1]) | (hist_q[0] & hist_q[2]) | (hist_q[1] & hist_q[2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      hist_q  <= '0;
      pin_out <= 1'b0;
    end else begin
      sync_q  <= {sync_q[SYNC_DEPTH-2:0], pin_in};
      hist_q  <= {hist_q[1:0], sync_q[SYNC_DEPTH-1]};
      pin_out <= vote;
    end
  end
endmodule

// File: rtl/qenc_step_decode.sv
module qenc_step_decode (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ab_in,
  output logic       step_up,
  output logic       step_dn,
  output logic       jump
);
  logic [1:0] prev_q;
  logic [1:0] diff;
  logic       single;

  assign diff   = prev_q ^ ab_in;
  assign single = (diff == 2'b01) || (diff == 2'b10);
  assign jump   = (diff == 2'b11);
  assign step_up = single &  (prev_q[1] ^ ab_in[0]);
  assign step_dn = single & ~(prev_q[1] ^ ab_in[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 2'b00;
    else        prev_q <= ab_in;
  end
endmodule

// File: rtl/qenc_velocity.sv
module qenc_velocity #(
  parameter int POS_W     = 32,
  parameter int WIN_W     = 24,
  parameter int WIN_RESET = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] pos_in,
  input  logic             win_wr,
  input  logic [WIN_W-1:0] win_data,
  output logic [WIN_W-1:0] win_len,
  output logic [POS_W-1:0] vel_out
);
  logic [WIN_W-1:0] win_cnt;
  logic [POS_W-1:0] base_q;
  logic             win_end;

  assign win_end = (win_len != '0) && (win_cnt == win_len - WIN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_len <= WIN_W'(WIN_RESET);
      win_cnt <= '0;
      base_q  <= '0;
      vel_out <= '0;
    end else if (win_wr) begin
      win_len <= win_data;
      win_cnt <= '0;
      base_q  <= pos_in;
    end else if (win_end) begin
      vel_out <= pos_in - base_q;
      base_q  <= pos_in;
      win_cnt <= '0;
    end else if (win_len != '0) begin
      win_cnt <= win_cnt + WIN_W'(1);
    end
  end

  p_win_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_len != '0) |-> (win_cnt < win_len));
endmodule

// File: rtl/qenc_tracker.sv
module qenc_tracker #(
  parameter int POS_W      = 32,
  parameter int WIN_W      = 24,
  parameter int WIN_RESET  = 100,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             enc_idx,
  input  logic [2:0]       reg_addr,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic [POS_W-1:0] reg_wdata,
  output logic [POS_W-1:0] reg_rdata,
  output logic             cmp_pulse
);
  import qenc_pkg::*;

  logic [NUM_PINS-1:0] pins_raw, pins_flt;
  logic step_up, step_dn, jump;
  logic [POS_W-1:0] pos_q, snap_q, tgt_q, vel_w;
  logic [WIN_W-1:0] win_w;
  logic pend_q, err_q, idx_prev_q, idx_rise, eq_prev_q, pos_eq;
  logic pos_load, snap_rd, err_clr, win_wr, tgt_wr;
  logic [POS_W-1:0] rd_mux;

  assign pins_raw = {enc_idx, enc_a, enc_b};

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_flt
    qenc_pin_filter #(.SYNC_DEPTH(SYNC_DEPTH)) u_flt (
      .clk(clk), .rst_n(rst_n), .pin_in(pins_raw[g]), .pin_out(pins_flt[g]));
  end

  qenc_step_decode u_dec (
    .clk(clk), .rst_n(rst_n), .ab_in(pins_flt[1:0]),
    .step_up(step_up), .step_dn(step_dn), .jump(jump));

  qenc_velocity #(.POS_W(POS_W), .WIN_W(WIN_W), .WIN_RESET(WIN_RESET)) u_vel (
    .clk(clk), .rst_n(rst_n), .pos_in(pos_q), .win_wr(win_wr),
    .win_data(reg_wdata[WIN_W-1:0]), .win_len(win_w), .vel_out(vel_w));

  assign pos_load = reg_wr && (reg_addr == RA_POS);
  assign err_clr  = reg_wr && (reg_addr == RA_STAT) && reg_wdata[ST_ERR];
  assign win_wr   = reg_wr && (reg_addr == RA_WIN);
  assign tgt_wr   = reg_wr && (reg_addr == RA_TGT);
  assign snap_rd  = reg_rd && (reg_addr == RA_SNAP);
  assign idx_rise = pins_flt[2] && !idx_prev_q;
  assign pos_eq   = (pos_q == tgt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (pos_load) begin
      pos_q <= reg_wdata;
    end else if (step_up) begin
      pos_q <= pos_q + POS_W'(1);
    end else if (step_dn) begin
      pos_q <= pos_q - POS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q      <= 1'b0;
      idx_prev_q <= 1'b0;
      pend_q     <= 1'b0;
      snap_q     <= '0;
      tgt_q      <= '0;
      eq_prev_q  <= 1'b1;
      cmp_pulse  <= 1'b0;
    end else begin
      if (jump)         err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
      idx_prev_q <= pins_flt[2];
      if (idx_rise && !pend_q) begin
        snap_q <= pos_q;
        pend_q <= 1'b1;
      end else if (snap_rd) begin
        pend_q <= 1'b0;
      end
      if (tgt_wr) tgt_q <= reg_wdata;
      eq_prev_q <= pos_eq;
      cmp_pulse <= pos_eq && !eq_prev_q;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_POS:  rd_mux = pos_q;
      RA_SNAP: rd_mux = snap_q;
      RA_STAT: rd_mux = {{(POS_W-2){1'b0}}, err_q, pend_q};
      RA_VEL:  rd_mux = vel_w;
      RA_WIN:  rd_mux = {{(POS_W-WIN_W){1'b0}}, win_w};
      RA_TGT:  rd_mux = tgt_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
    else             reg_rdata <= '0;
  end

  p_pos_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pos_load |=> ((pos_q == $past(pos_q)) || (pos_q == $past(pos_q) + POS_W'(1)) ||
                   (pos_q == $past(pos_q) - POS_W'(1))));
  p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr) |=> err_q);
  p_snap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !snap_rd) |=> ($stable(snap_q) && pend_q));
  p_cmp_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_pulse |=> !cmp_pulse);
endmodule

// File: tb/sim_qenc_tracker.sv
module sim_qenc_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_rd = 1'b0, reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic cmp_pulse;

  int checks = 0;
  int failures = 0;
  int pulses = 0;
  int phase = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  qenc_tracker u0 (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cmp_pulse(cmp_pulse));

  // behavioural reference, advanced on every rising edge
  logic [2:0]  m_s1, m_s2, m_f;
  logic [2:0]  m_h [0:2];
  logic [1:0]  m_pab;
  logic [31:0] m_pos, m_snap, m_tgt, m_vel, m_base, m_rdata;
  logic [23:0] m_win, m_cnt;
  logic m_err, m_pend, m_idxp, m_preq, m_cmp;
  string m_tag = "R9";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_f = '0; m_pab = '0;
      for (int k = 0; k < 3; k++) m_h[k] = '0;
      m_pos = '0; m_snap = '0; m_tgt = '0; m_vel = '0; m_base = '0; m_rdata = '0;
      m_win = 24'd100; m_cnt = '0;
      m_err = 0; m_pend = 0; m_idxp = 0; m_preq = 1; m_cmp = 0;
    end else begin
      logic [1:0] ab, df;
      logic up, dn, jmp, rise, eq;
      logic [31:0] old_pos;
      ab = m_f[1:0];
      df = m_pab ^ ab;
      jmp = (df == 2'b11);
      up = (df == 2'b01 || df == 2'b10) && (m_pab[1] != ab[0]);
      dn = (df == 2'b01 || df == 2'b10) && (m_pab[1] == ab[0]);
      rise = m_f[2] && !m_idxp;
      old_pos = m_pos;
      eq = (m_pos == m_tgt);
      if (reg_rd) begin
        case (reg_addr)
          3'd0: begin m_rdata = m_pos; m_tag = "R2"; end
          3'd1: begin m_rdata = m_snap; m_tag = "R5"; end
          3'd2: begin m_rdata = {30'd0, m_err, m_pend}; m_tag = "R3"; end
          3'd3: begin m_rdata = m_vel; m_tag = "R7"; end
          3'd4: begin m_rdata = {8'd0, m_win}; m_tag = "R7"; end
          3'd5: begin m_rdata = m_tgt; m_tag = "R8"; end
          default: begin m_rdata = '0; m_tag = "R9"; end
        endcase
      end else begin
        m_rdata = '0; m_tag = "R9";
      end
      if (reg_wr && reg_addr == 3'd4) begin
        m_win = reg_wdata[23:0]; m_cnt = '0; m_base = old_pos;
      end else if (m_win != 0) begin
        if (m_cnt == m_win - 24'd1) begin
          m_vel = old_pos - m_base; m_base = old_pos; m_cnt = '0;
        end else m_cnt = m_cnt + 24'd1;
      end
      if (rise && !m_pend) begin m_snap = old_pos; m_pend = 1; end
      else if (reg_rd && reg_addr == 3'd1) m_pend = 0;
      if (jmp) m_err = 1;
      else if (reg_wr && reg_addr == 3'd2 && reg_wdata[1]) m_err = 0;
      if (reg_wr && reg_addr == 3'd5) m_tgt = reg_wdata;
      m_cmp = eq && !m_preq;
      m_preq = eq;
      if (reg_wr && reg_addr == 3'd0) m_pos = reg_wdata;
      else if (up) m_pos = m_pos + 32'd1;
      else if (dn) m_pos = m_pos - 32'd1;
      m_idxp = m_f[2];
      m_pab = ab;
      m_f = (m_h[0] & m_h[1]) | (m_h[0] & m_h[2]) | (m_h[1] & m_h[2]);
      m_h[2] = m_h[1]; m_h[1] = m_h[0]; m_h[0] = m_s2;
      m_s2 = m_s1;
      m_s1 = {enc_idx, enc_a, enc_b};
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R8", {31'd0, cmp_pulse}, {31'd0, m_cmp});
      check(m_tag, reg_rdata, m_rdata);
      if (cmp_pulse) pulses++;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic set_phase();
    case (phase)
      0: {enc_a, enc_b} = 2'b00;
      1: {enc_a, enc_b} = 2'b01;
      2: {enc_a, enc_b} = 2'b11;
      default: {enc_a, enc_b} = 2'b10;
    endcase
  endtask

  task automatic move(input int n, input bit fwd);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      phase = fwd ? (phase + 1) % 4 : (phase + 3) % 4;
      set_phase();
      repeat (7) @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic index_pulse();
    @(negedge clk); enc_idx = 1;
    idle(6);
    enc_idx = 0;
    idle(8);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst_n = 1;
    idle(2);
    rd(3'd0, v); check("R2 reset", v, 32'd0);
    rd(3'd2, v); check("R9 reset status", v, 32'd0);
    rd(3'd4, v); check("R7 reset window", v, 32'd100);
    check("R8 no pulse at reset", pulses, 0);

    move(10, 1);
    rd(3'd0, v); check("R2 forward", v, 32'd10);
    move(3, 0);
    rd(3'd0, v); check("R2 reverse", v, 32'd7);

    @(negedge clk); enc_a = ~enc_a;
    @(negedge clk); enc_a = ~enc_a;
    idle(10);
    rd(3'd0, v); check("R1 glitch ignored", v, 32'd7);
    rd(3'd2, v); check("R1 no error from glitch", v, 32'd0);

    @(negedge clk); phase = (phase + 2) % 4; set_phase();
    idle(10);
    rd(3'd0, v); check("R3 jump no count", v, 32'd7);
    rd(3'd2, v); check("R3 error sticky", v, 32'd2);
    wr(3'd2, 32'd2);
    rd(3'd2, v); check("R3 error cleared", v, 32'd0);

    wr(3'd0, 32'h7FFF_FFFF);
    rd(3'd0, v); check("R4 load", v, 32'h7FFF_FFFF);
    move(1, 1);
    rd(3'd0, v); check("R4 wrap", v, 32'h8000_0000);

    wr(3'd0, 32'd100);
    index_pulse();
    rd(3'd2, v); check("R5 pending set", v, 32'd1);
    move(4, 1);
    index_pulse();
    rd(3'd2, v); check("R6 still pending", v, 32'd1);
    rd(3'd1, v); check("R6 snapshot held", v, 32'd100);
    rd(3'd2, v); check("R6 pending cleared by read", v, 32'd0);
    index_pulse();
    rd(3'd1, v); check("R5 new snapshot", v, 32'd104);

    wr(3'd3, 32'hDEAD_BEEF);
    wr(3'd7, 32'd55);
    wr(3'd4, 32'd1000);
    move(10, 1);
    idle(1000);
    rd(3'd3, v); check("R7 velocity", v, 32'd10);
    idle(1000);
    rd(3'd3, v); check("R7 velocity idle", v, 32'd0);
    wr(3'd4, 32'd0);
    move(5, 0);
    idle(300);
    rd(3'd3, v); check("R7 window off holds", v, 32'd0);
    wr(3'd4, 32'd37);
    move(12, 0);
    move(6, 1);
    idle(50);

    wr(3'd0, 32'd500);
    wr(3'd5, 32'd503);
    idle(4);
    pulses = 0;
    move(3, 1);
    idle(4);
    check("R8 pulse forward", pulses, 1);
    move(1, 1);
    move(1, 0);
    idle(4);
    check("R8 pulse reverse approach", pulses, 2);
    idle(20);
    check("R8 no repeat while equal", pulses, 2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule